// File: doc/BRIEF.md
# Prioritized Fast Interrupt Controller

This block collects eight fast-interrupt request lines, ranks them by a per-line programmable 3-bit urgency code, and drives one fast-interrupt line toward the processor. A request is captured on the rising edge of its input and stays pending until the processor takes it. The processor takes a request by reading the vector register. That read returns the winning line number and, as a side effect, moves the line from pending to in service.

Service routines may nest. A pending request can interrupt the running service only if its code is strictly more urgent than that of every line currently in service. A write of any data to the end-of-service register retires the most urgent line in service. The in-service register shows which lines are being handled. All registers sit on a single-cycle synchronous bus. Read data is combinational from the address in the same cycle, and any side effect takes place at the next rising clock edge.

Top module: `fiq_prio_ctrl`

## Requirements
- R1: After reset every priority register reads 7, the in-service register reads 0, `fiq_o` is low and a vector read returns 0xFFFF_FFFF.
- R2: A request becomes pending at the clock edge that follows a 0-to-1 transition on its `src_i` bit, and it stays pending until it is acknowledged. A line held high does not raise a new request after it has been acknowledged.
- R3: Among eligible pending lines, the one with the numerically lowest priority code wins (code 0 is the most urgent). Equal codes resolve to the lower line number. A vector read returns the winner's number in bits 2..0 and ones in bits 31..3.
- R4: A vector read that has a winner clears that line's pending bit and sets its in-service bit at the same clock edge. A vector read with no winner returns 0xFFFF_FFFF and changes no state.
- R5: A pending line is eligible only if its priority code is strictly lower than the code of every line currently in service.
- R6: `fiq_o` is high exactly when at least one eligible pending request exists.
- R7: A write of any data to address 0x1 clears the in-service bit of the in-service line with the lowest priority code (ties go to the lower line number). The write is ignored when nothing is in service.
- R8: Priority registers sit at addresses 0x8 to 0xF, one for each line in line order. Each holds 3 bits in bits 2..0 and reads 0 in bits 31..3.
- R9: The vector register is at 0x0 and is read-only. The in-service register is at 0x2 and is read-only, with bit i for line i in bits 7..0. Unmapped addresses and unused bits read 0, and writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 8 | Fast-interrupt request lines, synchronous to clk_i |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe; a read of the vector register acknowledges |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, valid in the same cycle |
| fiq_o | output | 1 | Fast-interrupt request to the processor |

## Verification
The hardest case to reach is a nested service that is blocked. This needs one line in service while another pending line carries an equal or less urgent code, followed by an end-of-service write that unblocks it. A directed sequence gives two lines the same code, raises both, takes one, and checks that the other is held off until retirement. A long random phase then mixes priority rewrites, edge toggles, acknowledges and end-of-service writes, so that stacks several levels deep and priority changes in mid-service occur many times. A bench model predicts every read and `fiq_o`.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
  localparam int N_SRC  = 8;
  localparam int PRIO_W = 3;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_VEC       = 4'h0;
  localparam logic [ADDR_W-1:0] A_EOI       = 4'h1;
  localparam logic [ADDR_W-1:0] A_ISR       = 4'h2;
  localparam logic [ADDR_W-1:0] A_PRIO_BASE = 4'h8;
endpackage

// File: rtl/fiq_req_latch.sv
module fiq_req_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_q, pend_q, rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      // a fresh edge wins over a same-cycle clear
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;

  // R2
  edge_captured_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/fiq_prio_bank.sv
module fiq_prio_bank #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [N-1:0]         sel_i,
  input  logic [PW-1:0]        wdata_i,
  output logic [N-1:0][PW-1:0] prio_o
);
  logic [N-1:0][PW-1:0] prio_q;

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                prio_q[k] <= '1;
      else if (we_i && sel_i[k])  prio_q[k] <= wdata_i;
    end

    // R8
    prio_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && sel_i[k]) |=> (prio_q[k] == $past(wdata_i)));
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/fiq_pick.sv
module fiq_pick #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]         mask_i,
  input  logic [N-1:0][PW-1:0] prio_i,
  output logic                 found_o,
  output logic [IW-1:0]        idx_o,
  output logic [PW-1:0]        prio_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    // strict compare keeps the lower index on ties
    for (int i = 0; i < N; i++) begin
      if (mask_i[i] && (!found_o || prio_i[i] < prio_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/fiq_prio_ctrl.sv
module fiq_prio_ctrl
  import fiq_pkg::*;
#(
  parameter int N  = N_SRC,
  parameter int PW = PRIO_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          fiq_o
);
  logic [N-1:0]         pend, elig, ack_oh, eoi_oh, prio_sel;
  logic [N-1:0][PW-1:0] prio;
  logic [N-1:0]         isr_q;
  logic                 win_found, isr_found, ack_fire, eoi_fire;
  logic [IW-1:0]        win_idx, isr_idx;
  logic [PW-1:0]        win_prio, isr_prio;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DW-1:PW];

  for (genvar k = 0; k < N; k++) begin : g_dec
    assign prio_sel[k] = (bus_addr_i == A_PRIO_BASE + AW'(k));
  end

  fiq_prio_bank #(.N(N), .PW(PW)) u_prio (
    .clk_i, .rst_ni,
    .we_i    (bus_we_i),
    .sel_i   (prio_sel),
    .wdata_i (bus_wdata_i[PW-1:0]),
    .prio_o  (prio)
  );

  fiq_req_latch #(.N(N)) u_req (
    .clk_i, .rst_ni,
    .src_i,
    .clr_i  (ack_oh),
    .pend_o (pend)
  );

  // most urgent line in service sets the nesting threshold
  fiq_pick #(.N(N), .PW(PW)) u_isr_pick (
    .mask_i (isr_q), .prio_i (prio),
    .found_o (isr_found), .idx_o (isr_idx), .prio_o (isr_prio)
  );

  for (genvar k = 0; k < N; k++) begin : g_elig
    assign elig[k] = pend[k] && (!isr_found || prio[k] < isr_prio);
  end

  fiq_pick #(.N(N), .PW(PW)) u_win_pick (
    .mask_i (elig), .prio_i (prio),
    .found_o (win_found), .idx_o (win_idx), .prio_o (win_prio)
  );

  assign fiq_o    = win_found;
  assign ack_fire = bus_re_i && (bus_addr_i == A_VEC) && win_found;
  assign eoi_fire = bus_we_i && (bus_addr_i == A_EOI) && isr_found;
  assign ack_oh   = ack_fire ? (N'(1) << win_idx) : '0;
  assign eoi_oh   = eoi_fire ? (N'(1) << isr_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~eoi_oh) | ack_oh;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_VEC) begin
      bus_rdata_o = win_found ? {{(DW-IW){1'b1}}, win_idx} : '1;
    end else if (bus_addr_i == A_ISR) begin
      bus_rdata_o = DW'(isr_q);
    end else begin
      for (int k = 0; k < N; k++)
        if (prio_sel[k]) bus_rdata_o = DW'(prio[k]);
    end
  end

  // R4
  ack_marks_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !eoi_fire) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

  // R4
  idle_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && bus_addr_i == A_VEC && !fiq_o) |-> (bus_rdata_o == '1));

  // R5
  nest_threshold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_o && isr_found) |-> (win_prio < isr_prio));

  // R7
  eoi_retires_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_fire && !ack_fire) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R7
  eoi_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_EOI && isr_q == '0 && !ack_fire) |=> (isr_q == '0));
endmodule

// File: tb/fiq_prio_ctrl_tb.sv
module fiq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit [7:0] m_pend = '0, m_isr = '0, m_prev = '0;
  bit [2:0] m_prio [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  fiq_prio_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq)
  );

  function automatic int isr_top();
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (m_isr[i] && (best < 0 || m_prio[i] < m_prio[best])) best = i;
    return best;
  endfunction

  function automatic int winner();
    int t = isr_top();
    int thr = (t < 0) ? 8 : int'(m_prio[t]);
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (m_pend[i] && int'(m_prio[i]) < thr && (best < 0 || m_prio[i] < m_prio[best]))
        best = i;
    return best;
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    int w = winner();
    if (a == 4'h0) return (w < 0) ? 32'hFFFF_FFFF : {29'h1FFF_FFFF, 3'(w)};
    if (a == 4'h2) return {24'h0, m_isr};
    if (a >= 4'h8) return {29'h0, m_prio[a - 4'h8]};
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(logic [7:0] s, logic r, logic w, logic [3:0] a,
                      logic [31:0] d, string tag);
    int win, top;
    bit [7:0] ack_m, eoi_m;
    @(negedge clk);
    src = s; re = r; we = w; addr = a; wdata = d;
    #1;
    win = winner();
    check("R6 fiq_o", {31'h0, fiq}, {31'h0, win >= 0});
    if (r) check(tag, rdata, exp_read(a));
    top = isr_top();
    ack_m = (r && a == 4'h0 && win >= 0) ? 8'(1 << win) : 8'h0;
    eoi_m = (w && a == 4'h1 && top >= 0) ? 8'(1 << top) : 8'h0;
    if (w && a >= 4'h8) m_prio[a - 4'h8] = d[2:0];
    m_pend = (m_pend & ~ack_m) | (s & ~m_prev);
    m_isr  = (m_isr & ~eoi_m) | ack_m;
    m_prev = s;
  endtask

  task automatic rd(logic [7:0] s, logic [3:0] a, string tag);
    step(s, 1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic wr(logic [7:0] s, logic [3:0] a, logic [31:0] d);
    step(s, 1'b0, 1'b1, a, d, "wr");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    for (int i = 0; i < 8; i++) m_prio[i] = 3'd7;
    repeat (3) @(posedge clk);
    #1;
    check("R1 fiq_o in reset", {31'h0, fiq}, 32'h0);
    rst_n = 1'b1;

    // R1 reset values
    for (int k = 0; k < 8; k++) rd(8'h0, 4'(8 + k), "R1 prio reset");
    rd(8'h0, 4'h2, "R1 isr reset");
    rd(8'h0, 4'h0, "R1 idle vector");
    rd(8'h0, 4'h2, "R4 idle read changes nothing");

    // R9 unmapped read, write to read-only regs
    rd(8'h0, 4'h5, "R9 unmapped reads zero");
    wr(8'h0, 4'h2, 32'hFFFF_FFFF);
    wr(8'h0, 4'h0, 32'hFFFF_FFFF);
    rd(8'h0, 4'h2, "R9 isr write ignored");
    rd(8'h0, 4'h0, "R9 vector write ignored");

    // R8 upper bits discarded
    wr(8'h0, 4'hB, 32'hFFFF_FFFA);
    rd(8'h0, 4'hB, "R8 prio upper bits zero");

    // R7 eoi with nothing in service
    wr(8'h0, 4'h1, 32'h1234_5678);
    rd(8'h0, 4'h2, "R7 empty eoi ignored");

    // R3 tie on equal codes, R5 equal code blocked while nested
    wr(8'h0, 4'hB, 32'h2);
    wr(8'h0, 4'hD, 32'h2);
    step(8'h28, 1'b0, 1'b0, 4'h0, 0, "idle");
    rd(8'h28, 4'h0, "R3 tie lower index");
    rd(8'h28, 4'h2, "R4 isr set by ack");
    rd(8'h28, 4'h0, "R5 equal code blocked");
    wr(8'h28, 4'h1, 32'h0);
    rd(8'h28, 4'h0, "R5 unblocked after eoi");
    // R2 held level does not retrigger
    rd(8'h28, 4'h0, "R2 no retrigger");
    wr(8'h28, 4'h1, 32'h0);
    rd(8'h00, 4'h2, "R7 all retired");

    // R5 more urgent preempts, R7 retires most urgent first
    wr(8'h0, 4'h8, 32'h5);
    wr(8'h0, 4'h9, 32'h1);
    step(8'h01, 1'b0, 1'b0, 4'h0, 0, "idle");
    rd(8'h01, 4'h0, "R3 single winner");
    step(8'h03, 1'b0, 1'b0, 4'h0, 0, "idle");
    rd(8'h03, 4'h0, "R5 nested preempt");
    wr(8'h03, 4'h1, 32'h0);
    rd(8'h03, 4'h2, "R7 most urgent retired");

    // random phase
    void'($urandom(32'd20240611));
    s = 8'h0;
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom % 10);
      if ($urandom % 3 == 0) s = s ^ 8'(1 << ($urandom % 8));
      case (op)
        0, 1, 2: rd(s, 4'h0, "R4 random ack");
        3, 4:    wr(s, 4'h1, $urandom);
        5:       wr(s, 4'(8 + $urandom % 8), $urandom);
        6:       rd(s, 4'h2, "R9 random isr");
        7:       rd(s, 4'(8 + $urandom % 8), "R8 random prio");
        8:       rd(s, 4'($urandom % 16), "R9 random addr");
        default: step(s, 1'b0, 1'b0, 4'h0, 0, "idle");
      endcase
    end
    finish_run();
  end
endmodule